// File: doc/BRIEF.md
# Load and Store Dispatch Queues

This block sits between the ALU and the memory interface of a load-store processor. Every effective address is computed by the ALU before it reaches this block, and the address arrives here as a dispatch. A load goes into its own first-in first-out queue together with the number of the register it will write. A store goes into a second queue together with the data it will write. Each queue offers its oldest entry to the memory side through a valid/ready handshake.

When a load is accepted, the block raises a one-cycle set request for that register toward the hazard scoreboard, so that later instructions reading the register will stall. Loads that have been issued return their data in issue order. The block tags each returned word with the register of the oldest outstanding load and raises a clear request for that register.

An abort input discards every entry that has not yet been issued. For each register that still had a load waiting, the block raises a clear request so that the scoreboard does not stall forever. Loads that were already issued still complete normally.

Top module: `lsq_dispatch`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `ld_req_valid`, `st_req_valid` and `wb_valid` are low, both hazard masks are zero, and `disp_ready` is high.
- R2: A dispatch with `disp_is_store`=0, accepted when `disp_valid` and `disp_ready` are both high at a clock edge, is queued as a load. Loads reach `ld_req_addr` in the order they were accepted, and `ld_req_valid` can rise the cycle after acceptance.
- R3: A dispatch with `disp_is_store`=1 is queued as a store. Stores reach `st_req_addr`/`st_req_data` in the order they were accepted, carrying their own address and data.
- R4: In the cycle after an accepted load, `hz_set_mask` has exactly bit `disp_reg` set. In every other cycle, including after stores, it is zero.
- R5: Each queue holds DEPTH (4) entries. `disp_ready` is low for a kind whose queue is full, while the other kind is still accepted.
- R6: An entry leaves a queue only at an edge where its valid and ready are both high. While ready is low, the head entry stays presented with its values unchanged.
- R7: Each `ld_rsp_valid` pairs with the oldest issued load that has not yet been answered. In the next cycle, `wb_valid`=1, `wb_reg` is that load's register, `wb_data` is the response data, and `hz_clr_mask` has that register's bit set. A response with no load outstanding is ignored: no `wb_valid` and no clear request.
- R8: At most DEPTH loads can be outstanding. While DEPTH loads are outstanding, `ld_req_valid` stays low. It rises the cycle after a response frees a slot.
- R9: An abort empties both queues. In the next cycle both request valids are low, and the flushed entries are never presented. Loads already issued still return with their correct tags.
- R10: In the cycle after an abort, `hz_clr_mask` holds the bit of every register that had at least one unissued load queued, ORed with the bit from any response taken in the same cycle.
- R11: While `abort` is high, `disp_ready`, `ld_req_valid` and `st_req_valid` are low, so neither a dispatch nor a memory handshake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Flush every unissued entry |
| disp_valid | input | 1 | Dispatch offered |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_addr | input | ADDR_W | Effective address from the ALU |
| disp_reg | input | log2(NREGS) | Destination register of a load |
| disp_data | input | DATA_W | Write data of a store |
| disp_ready | output | 1 | Dispatch can be accepted |
| ld_req_valid | output | 1 | Load head is offered to memory |
| ld_req_addr | output | ADDR_W | Load head address |
| ld_req_ready | input | 1 | Memory takes the load |
| ld_rsp_valid | input | 1 | Load data returned |
| ld_rsp_data | input | DATA_W | Returned load data |
| st_req_valid | output | 1 | Store head is offered to memory |
| st_req_addr | output | ADDR_W | Store head address |
| st_req_data | output | DATA_W | Store head data |
| st_req_ready | input | 1 | Memory takes the store |
| wb_valid | output | 1 | Tagged load result valid |
| wb_reg | output | log2(NREGS) | Register the result belongs to |
| wb_data | output | DATA_W | Result data |
| hz_set_mask | output | NREGS | Registers to mark as waiting |
| hz_clr_mask | output | NREGS | Registers to mark as ready |

## Verification
The bench sends loads to all sixteen registers in four full batches, so every queue slot and every pointer wrap is exercised. A tag or pointer error would then misroute a write-back or reorder addresses. It fills each queue to check that only the full kind is refused; a shared full flag would block the other kind as well. It holds ready low to catch a head that advances without a handshake. It fills the outstanding-load limit to catch a design that overwrites its response tags. It aborts with a duplicated register pending and a response arriving in the same cycle. A design that drops the clear request, counts pending loads wrongly or loses the in-flight tag would show up in the clear mask or in `wb_reg`.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned LSQ_ADDR_W = 32;
  localparam int unsigned LSQ_DATA_W = 32;
  localparam int unsigned LSQ_NREGS  = 16;
  localparam int unsigned LSQ_DEPTH  = 4;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_LOAD,
    ACT_STORE,
    ACT_FLUSH
  } disp_act_e;
endpackage

// File: rtl/lsq_fifo.sv
module lsq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  // storage without reset so that it maps onto distributed or block RAM
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          do_push, do_pop;

  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  assign dout = mem[rptr];

  always_comb begin
    cnt_nx = cnt;
    if (do_push && !do_pop)      cnt_nx = cnt + 1'b1;
    else if (do_pop && !do_push) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
      cnt   <= cnt_nx;
      full  <= (cnt_nx == CW'(DEPTH));
      empty <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/lsq_pend_track.sv
module lsq_pend_track #(
  parameter int NREGS = 16,
  parameter int DEPTH = 4,
  localparam int RW   = $clog2(NREGS),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             inc,
  input  logic [RW-1:0]    inc_reg,
  input  logic             dec,
  input  logic [RW-1:0]    dec_reg,
  output logic [NREGS-1:0] pend
);
  // one small counter per register: number of unissued loads aimed at it
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [CW-1:0] c;
    logic          hit_inc, hit_dec;

    assign hit_inc = inc && (inc_reg == RW'(g));
    assign hit_dec = dec && (dec_reg == RW'(g));

    always_ff @(posedge clk) begin
      if (rst || flush)            c <= '0;
      else if (hit_inc && !hit_dec) c <= c + 1'b1;
      else if (hit_dec && !hit_inc) c <= c - 1'b1;
    end

    assign pend[g] = (c != '0);
  end
endmodule

// File: rtl/lsq_dispatch.sv
module lsq_dispatch
  import lsq_pkg::*;
#(
  parameter int ADDR_W = LSQ_ADDR_W,
  parameter int DATA_W = LSQ_DATA_W,
  parameter int NREGS  = LSQ_NREGS,
  parameter int DEPTH  = LSQ_DEPTH,
  localparam int RW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              disp_valid,
  input  logic              disp_is_store,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic [RW-1:0]     disp_reg,
  input  logic [DATA_W-1:0] disp_data,
  output logic              disp_ready,
  output logic              ld_req_valid,
  output logic [ADDR_W-1:0] ld_req_addr,
  input  logic              ld_req_ready,
  input  logic              ld_rsp_valid,
  input  logic [DATA_W-1:0] ld_rsp_data,
  output logic              st_req_valid,
  output logic [ADDR_W-1:0] st_req_addr,
  output logic [DATA_W-1:0] st_req_data,
  input  logic              st_req_ready,
  output logic              wb_valid,
  output logic [RW-1:0]     wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic [NREGS-1:0]  hz_set_mask,
  output logic [NREGS-1:0]  hz_clr_mask
);
  localparam int LW = ADDR_W + RW;
  localparam int SW = ADDR_W + DATA_W;
  localparam logic [NREGS-1:0] BIT0 = NREGS'(1);

  disp_act_e act;
  logic ldq_full, ldq_empty, stq_full, stq_empty, tag_full, tag_empty;
  logic ld_push, st_push, ld_issue, st_issue, rsp_take;
  logic [RW-1:0]     ld_head_reg, tag_head;
  logic [NREGS-1:0]  pend;

  always_comb begin
    if (abort)              act = ACT_FLUSH;
    else if (!disp_valid)   act = ACT_IDLE;
    else if (disp_is_store) act = ACT_STORE;
    else                    act = ACT_LOAD;
  end

  assign disp_ready = !abort && (disp_is_store ? !stq_full : !ldq_full);
  assign ld_push    = (act == ACT_LOAD) && !ldq_full;
  assign st_push    = (act == ACT_STORE) && !stq_full;

  assign ld_req_valid = !ldq_empty && !tag_full && !abort;
  assign st_req_valid = !stq_empty && !abort;
  assign ld_issue     = ld_req_valid && ld_req_ready;
  assign st_issue     = st_req_valid && st_req_ready;
  assign rsp_take     = ld_rsp_valid && !tag_empty;

  lsq_fifo #(.W(LW), .DEPTH(DEPTH)) ldq_i (
    .clk(clk), .rst(rst), .flush(abort),
    .push(ld_push), .din({disp_addr, disp_reg}),
    .pop(ld_issue), .dout({ld_req_addr, ld_head_reg}),
    .full(ldq_full), .empty(ldq_empty)
  );

  lsq_fifo #(.W(SW), .DEPTH(DEPTH)) stq_i (
    .clk(clk), .rst(rst), .flush(abort),
    .push(st_push), .din({disp_addr, disp_data}),
    .pop(st_issue), .dout({st_req_addr, st_req_data}),
    .full(stq_full), .empty(stq_empty)
  );

  // registers of issued loads, oldest first; not touched by abort
  lsq_fifo #(.W(RW), .DEPTH(DEPTH)) tagq_i (
    .clk(clk), .rst(rst), .flush(1'b0),
    .push(ld_issue), .din(ld_head_reg),
    .pop(rsp_take), .dout(tag_head),
    .full(tag_full), .empty(tag_empty)
  );

  lsq_pend_track #(.NREGS(NREGS), .DEPTH(DEPTH)) pend_i (
    .clk(clk), .rst(rst), .flush(abort),
    .inc(ld_push), .inc_reg(disp_reg),
    .dec(ld_issue), .dec_reg(ld_head_reg),
    .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      wb_reg      <= '0;
      wb_data     <= '0;
      hz_set_mask <= '0;
      hz_clr_mask <= '0;
    end else begin
      wb_valid <= rsp_take;
      if (rsp_take) begin
        wb_reg  <= tag_head;
        wb_data <= ld_rsp_data;
      end
      hz_set_mask <= ld_push ? (BIT0 << disp_reg) : '0;
      hz_clr_mask <= (abort ? pend : '0) | (rsp_take ? (BIT0 << tag_head) : '0);
    end
  end
endmodule

// File: rtl/lsq_dispatch_chk.sv
module lsq_dispatch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int RW    = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              abort,
  input logic              disp_valid,
  input logic              disp_is_store,
  input logic [RW-1:0]     disp_reg,
  input logic              disp_ready,
  input logic              ld_req_valid,
  input logic [ADDR_W-1:0] ld_req_addr,
  input logic              ld_req_ready,
  input logic              st_req_valid,
  input logic [ADDR_W-1:0] st_req_addr,
  input logic [DATA_W-1:0] st_req_data,
  input logic              st_req_ready,
  input logic              wb_valid,
  input logic [RW-1:0]     wb_reg,
  input logic [NREGS-1:0]  hz_set_mask,
  input logic [NREGS-1:0]  hz_clr_mask
);
  localparam logic [NREGS-1:0] BIT0 = NREGS'(1);

  // R9
  abort_empties_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!ld_req_valid && !st_req_valid));

  // R6
  ld_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_req_valid && !ld_req_ready) |=> (abort || (ld_req_valid && $stable(ld_req_addr))));

  // R6
  st_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_req_valid && !st_req_ready) |=>
      (abort || (st_req_valid && $stable(st_req_addr) && $stable(st_req_data))));

  // R4
  set_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready && !disp_is_store) |=> (hz_set_mask == (BIT0 << $past(disp_reg))));

  // R4
  no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !(disp_valid && disp_ready && !disp_is_store) |=> (hz_set_mask == '0));

  // R4
  set_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hz_set_mask));

  // R7
  wb_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> hz_clr_mask[wb_reg]);
endmodule

bind lsq_dispatch lsq_dispatch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) chk_i (.*);

// File: tb/lsq_dispatch_tb_top.sv
module lsq_dispatch_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NREGS  = 16;
  localparam int DEPTH  = 4;
  localparam int RW     = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abort = 1'b0;
  logic disp_valid = 1'b0, disp_is_store = 1'b0;
  logic [ADDR_W-1:0] disp_addr = '0;
  logic [RW-1:0]     disp_reg = '0;
  logic [DATA_W-1:0] disp_data = '0;
  logic disp_ready;
  logic ld_req_valid, ld_req_ready = 1'b0;
  logic [ADDR_W-1:0] ld_req_addr;
  logic ld_rsp_valid = 1'b0;
  logic [DATA_W-1:0] ld_rsp_data = '0;
  logic st_req_valid, st_req_ready = 1'b0;
  logic [ADDR_W-1:0] st_req_addr;
  logic [DATA_W-1:0] st_req_data;
  logic wb_valid;
  logic [RW-1:0] wb_reg;
  logic [DATA_W-1:0] wb_data;
  logic [NREGS-1:0] hz_set_mask, hz_clr_mask;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsq_dispatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .abort(abort),
    .disp_valid(disp_valid), .disp_is_store(disp_is_store), .disp_addr(disp_addr),
    .disp_reg(disp_reg), .disp_data(disp_data), .disp_ready(disp_ready),
    .ld_req_valid(ld_req_valid), .ld_req_addr(ld_req_addr), .ld_req_ready(ld_req_ready),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .st_req_valid(st_req_valid), .st_req_addr(st_req_addr), .st_req_data(st_req_data),
    .st_req_ready(st_req_ready),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .hz_set_mask(hz_set_mask), .hz_clr_mask(hz_clr_mask)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ld_addr(input int r);
    return 32'h4000_0000 + 32'(r) * 32'd16;
  endfunction

  function automatic logic [DATA_W-1:0] rsp_val(input int r);
    return 32'hD000_0000 ^ (32'(r) * 32'h0101_0101);
  endfunction

  function automatic logic [NREGS-1:0] bitof(input int r);
    return NREGS'(1) << r;
  endfunction

  task automatic put_load(input int r, input logic [ADDR_W-1:0] a);
    disp_valid = 1'b1; disp_is_store = 1'b0; disp_reg = RW'(r); disp_addr = a;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic respond(input int exp_reg, input logic [DATA_W-1:0] d);
    ld_rsp_valid = 1'b1; ld_rsp_data = d;
    tick();
    ld_rsp_valid = 1'b0;
    chk("R7 wb_valid", 64'(wb_valid), 64'd1);
    chk("R7 wb_reg", 64'(wb_reg), 64'(exp_reg));
    chk("R7 wb_data", 64'(wb_data), 64'(d));
    chk("R7 clear mask", 64'(hz_clr_mask), 64'(bitof(exp_reg)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("ERROR: watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 during reset
    chk("R1 ld_req_valid", 64'(ld_req_valid), 64'd0);
    chk("R1 st_req_valid", 64'(st_req_valid), 64'd0);
    chk("R1 wb_valid", 64'(wb_valid), 64'd0);
    chk("R1 masks", 64'({hz_set_mask, hz_clr_mask}), 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 disp_ready", 64'(disp_ready), 64'd1);
    chk("R1 ld_req_valid after", 64'(ld_req_valid), 64'd0);

    // loads for every register, four full batches
    for (int b = 0; b < NREGS / DEPTH; b++) begin
      for (int i = 0; i < DEPTH; i++) begin
        disp_valid = 1'b1; disp_is_store = 1'b0;
        disp_reg = RW'(b * DEPTH + i); disp_addr = ld_addr(b * DEPTH + i);
        #1;
        chk("R5 ready before full", 64'(disp_ready), 64'd1);
        tick();
        chk("R4 set mask", 64'(hz_set_mask), 64'(bitof(b * DEPTH + i)));
      end
      disp_reg = RW'(b); #1;
      chk("R5 load refused when full", 64'(disp_ready), 64'd0);
      disp_is_store = 1'b1; #1;
      chk("R5 store still accepted", 64'(disp_ready), 64'd1);
      disp_valid = 1'b0; disp_is_store = 1'b0;
      tick();
      chk("R4 no set without load", 64'(hz_set_mask), 64'd0);
      for (int i = 0; i < DEPTH; i++) begin
        if ((b + i) % 2 == 1) begin
          ld_req_ready = 1'b0;
          tick();
          chk("R6 held load valid", 64'(ld_req_valid), 64'd1);
          chk("R6 held load addr", 64'(ld_req_addr), 64'(ld_addr(b * DEPTH + i)));
        end
        chk("R2 load valid", 64'(ld_req_valid), 64'd1);
        chk("R2 load order", 64'(ld_req_addr), 64'(ld_addr(b * DEPTH + i)));
        ld_req_ready = 1'b1;
        tick();
        ld_req_ready = 1'b0;
      end
      chk("R2 load queue drained", 64'(ld_req_valid), 64'd0);
      for (int i = 0; i < DEPTH; i++) respond(b * DEPTH + i, rsp_val(b * DEPTH + i));
      ld_rsp_valid = 1'b1; ld_rsp_data = 32'hBAD0_0000;
      tick();
      ld_rsp_valid = 1'b0;
      chk("R7 stray response wb", 64'(wb_valid), 64'd0);
      chk("R7 stray response clear", 64'(hz_clr_mask), 64'd0);
    end

    // stores
    for (int i = 0; i < DEPTH; i++) begin
      disp_valid = 1'b1; disp_is_store = 1'b1;
      disp_addr = 32'h2000_0000 + 32'(i) * 32'd8;
      disp_data = 32'hA5A5_0000 + 32'(i) * 32'h1111;
      tick();
      chk("R4 store sets nothing", 64'(hz_set_mask), 64'd0);
    end
    #1;
    chk("R5 store refused when full", 64'(disp_ready), 64'd0);
    disp_is_store = 1'b0; #1;
    chk("R5 load still accepted", 64'(disp_ready), 64'd1);
    disp_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      st_req_ready = 1'b0;
      tick(); tick();
      chk("R6 store held", 64'(st_req_valid), 64'd1);
      chk("R3 store addr", 64'(st_req_addr), 64'(32'h2000_0000 + 32'(i) * 32'd8));
      chk("R3 store data", 64'(st_req_data), 64'(32'hA5A5_0000 + 32'(i) * 32'h1111));
      st_req_ready = 1'b1;
      tick();
    end
    st_req_ready = 1'b0;
    chk("R3 store queue drained", 64'(st_req_valid), 64'd0);

    // R8 outstanding limit
    for (int r = 1; r <= DEPTH; r++) put_load(r, 32'h8000_0000 | (32'(r) << 4));
    ld_req_ready = 1'b1;
    repeat (DEPTH) tick();
    ld_req_ready = 1'b0;
    put_load(9, 32'h8000_0090);
    tick();
    chk("R8 blocked at limit", 64'(ld_req_valid), 64'd0);
    respond(1, 32'h1111_0001);
    chk("R8 slot freed", 64'(ld_req_valid), 64'd1);
    chk("R8 pending addr", 64'(ld_req_addr), 64'h8000_0090);

    // abort with pending loads, a store, and a response in the same cycle
    put_load(12, 32'h8000_00C0);
    put_load(9, 32'h8000_0091);
    disp_valid = 1'b1; disp_is_store = 1'b1; disp_addr = 32'h3000_0000; disp_data = 32'h5;
    tick();
    abort = 1'b1; disp_valid = 1'b1; disp_is_store = 1'b0; disp_reg = RW'(7);
    ld_req_ready = 1'b1; st_req_ready = 1'b1;
    ld_rsp_valid = 1'b1; ld_rsp_data = 32'h2222_0002;
    #1;
    chk("R11 dispatch blocked", 64'(disp_ready), 64'd0);
    chk("R11 load req blocked", 64'(ld_req_valid), 64'd0);
    chk("R11 store req blocked", 64'(st_req_valid), 64'd0);
    tick();
    abort = 1'b0; disp_valid = 1'b0; ld_rsp_valid = 1'b0;
    chk("R10 clear mask", 64'(hz_clr_mask), 64'(bitof(9) | bitof(12) | bitof(2)));
    chk("R11 no set on abort", 64'(hz_set_mask), 64'd0);
    chk("R9 load flushed", 64'(ld_req_valid), 64'd0);
    chk("R9 store flushed", 64'(st_req_valid), 64'd0);
    chk("R9 inflight wb", 64'(wb_reg), 64'd2);
    tick(); tick();
    chk("R9 stays empty", 64'({ld_req_valid, st_req_valid}), 64'd0);
    chk("R10 clear is one cycle", 64'(hz_clr_mask), 64'd0);
    respond(3, 32'h3333_0003);
    respond(4, 32'h4444_0004);
    ld_req_ready = 1'b0; st_req_ready = 1'b0;
    put_load(6, 32'h8000_0060);
    chk("R2 works after abort", 64'(ld_req_valid), 64'd1);
    chk("R2 addr after abort", 64'(ld_req_addr), 64'h8000_0060);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule